// File: doc/BRIEF.md
# Local Exclusive Access Monitor

This block keeps the per-core half of an exclusive-access scheme. One processor issues an exclusive load to claim a memory region. It later issues an exclusive store to the same region, and the monitor decides whether that store may go ahead. Between the two, the processor's own ordinary stores and loads are reported to the monitor. A store into the claimed region breaks the claim. A load does not.

The monitor does not move any data. For each exclusive store it returns a status one cycle later: 0 means the store is allowed locally, 1 means it is refused. A store that is allowed locally must still be confirmed by a separate system-wide monitor before memory is written. Regions are compared on a coarse tag formed by clearing the low `IGN_BITS` address bits. The transfer size recorded by the exclusive load must also equal the size of the exclusive store. An ordinary load carries only a strobe, because its address can never change the monitor's state.

Top module: `excl_local_monitor`

## Requirements
- R1: After reset the monitor is open with no recorded size, `stx_done_o` is low, and an exclusive store issued before any exclusive load fails (status 1).
- R2: An exclusive load arms the monitor and records the tag and size of its own access, whatever the earlier state. A second exclusive load replaces the first record.
- R3: An exclusive store passes (status 0) only when the monitor is armed and both the tag and the size match the record. Otherwise it fails (status 1). The status appears on `stx_status_o` in the cycle after the strobe, qualified by `stx_done_o`.
- R4: Tags are the address with bits IGN_BITS-1..0 cleared (default bits 10..0). Addresses that differ only in those bits match, and a difference in any higher bit fails the store.
- R5: Size encoding is none=0, byte=1, halfword=2, word=4. An exclusive store whose size differs from the recorded size fails.
- R6: After every exclusive store, whether it passed or failed, the monitor is open with size none, so a repeated exclusive store fails.
- R7: An ordinary store whose tag matches the record while the monitor is armed returns the monitor to open. An ordinary store to another tag has no effect.
- R8: An ordinary load has no effect on the state, tag or size.
- R9: Strobes in the same cycle resolve by priority: exclusive store, then exclusive load, then ordinary store, then ordinary load. Only the winner acts. An exclusive store is judged against the state before that cycle.
- R10: `stx_done_o` is high for exactly one cycle after each exclusive store strobe and low at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_vld_i | input | 1 | Ordinary load strobe |
| ldx_vld_i | input | 1 | Exclusive load strobe |
| ldx_addr_i | input | ADDR_W | Exclusive load address |
| ldx_size_i | input | 3 | Exclusive load size (0,1,2,4) |
| st_vld_i | input | 1 | Ordinary store strobe |
| st_addr_i | input | ADDR_W | Ordinary store address |
| stx_vld_i | input | 1 | Exclusive store strobe |
| stx_addr_i | input | ADDR_W | Exclusive store address |
| stx_size_i | input | 3 | Exclusive store size (0,1,2,4) |
| stx_done_o | output | 1 | Exclusive store result valid |
| stx_status_o | output | 1 | 0 = allowed locally, 1 = refused |

## Verification
The bench builds the monitor with its defaults: a 32-bit address and IGN_BITS of 11. These values place the granule boundary at 0x800, so addresses such as 0x17FC and 0x1800 sit just inside and just outside the granule of 0x1000. The 32-bit width leaves room for the tag bits above the boundary that decide a mismatch. The bench also applies collisions of the strobes in a single cycle and exclusive stores on consecutive cycles, so the ordering in R9 and the one-cycle result in R10 are both exercised.

// File: rtl/lxm_pkg.sv
package lxm_pkg;
   typedef enum logic [2:0] {
      SZ_NONE = 3'd0,
      SZ_BYTE = 3'd1,
      SZ_HALF = 3'd2,
      SZ_WORD = 3'd4
   } xsize_e;

   typedef enum logic {
      MON_OPEN = 1'b0,
      MON_EXCL = 1'b1
   } mstate_e;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_LD,
      OP_ST,
      OP_LDX,
      OP_STX
   } mop_e;
endpackage

// File: rtl/lxm_tag.sv
module lxm_tag #(
   parameter int ADDR_W   = 32,
   parameter int IGN_BITS = 11
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] tag_o
);
   localparam logic [ADDR_W-1:0] LOW_ONES = (ADDR_W'(1) << IGN_BITS) - ADDR_W'(1);
   localparam logic [ADDR_W-1:0] TAG_MASK = ~LOW_ONES;

   generate
      if (IGN_BITS == 0) begin : g_exact
         assign tag_o = addr_i;
      end else begin : g_coarse
         assign tag_o = addr_i & TAG_MASK;
      end
   endgenerate
endmodule

// File: rtl/lxm_arbiter.sv
module lxm_arbiter
   import lxm_pkg::*;
(
   input  logic ld_vld_i,
   input  logic ldx_vld_i,
   input  logic st_vld_i,
   input  logic stx_vld_i,
   output mop_e op_o
);
   always_comb begin
      if (stx_vld_i)      op_o = OP_STX;
      else if (ldx_vld_i) op_o = OP_LDX;
      else if (st_vld_i)  op_o = OP_ST;
      else if (ld_vld_i)  op_o = OP_LD;
      else                op_o = OP_NONE;
   end
endmodule

// File: rtl/lxm_state.sv
module lxm_state
   import lxm_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mop_e              op_i,
   input  logic [ADDR_W-1:0] ldx_tag_i,
   input  xsize_e            ldx_size_i,
   input  logic [ADDR_W-1:0] st_tag_i,
   output mstate_e           state_o,
   output logic [ADDR_W-1:0] tag_o,
   output xsize_e            size_o
);
   mstate_e           state_d;
   logic [ADDR_W-1:0] tag_d;
   xsize_e            size_d;

   always_comb begin
      state_d = state_o;
      tag_d   = tag_o;
      size_d  = size_o;
      case (op_i)
         OP_STX: begin
            state_d = MON_OPEN;
            size_d  = SZ_NONE;
         end
         OP_LDX: begin
            state_d = MON_EXCL;
            tag_d   = ldx_tag_i;
            size_d  = ldx_size_i;
         end
         OP_ST: begin
            if (state_o == MON_EXCL && st_tag_i == tag_o) begin
               state_d = MON_OPEN;
               size_d  = SZ_NONE;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_o <= MON_OPEN;
         tag_o   <= '0;
         size_o  <= SZ_NONE;
      end else begin
         state_o <= state_d;
         tag_o   <= tag_d;
         size_o  <= size_d;
      end
   end
endmodule

// File: rtl/lxm_judge.sv
module lxm_judge
   import lxm_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stx_vld_i,
   input  logic [ADDR_W-1:0] stx_tag_i,
   input  xsize_e            stx_size_i,
   input  mstate_e           state_i,
   input  logic [ADDR_W-1:0] tag_i,
   input  xsize_e            size_i,
   output logic              done_o,
   output logic              status_o
);
   logic allow;

   always_comb begin
      allow = (state_i == MON_EXCL) && (stx_tag_i == tag_i) && (stx_size_i == size_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o   <= 1'b0;
         status_o <= 1'b0;
      end else begin
         done_o   <= stx_vld_i;
         status_o <= stx_vld_i & ~allow;
      end
   end
endmodule

// File: rtl/excl_local_monitor.sv
module excl_local_monitor
   import lxm_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int IGN_BITS = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_vld_i,
   input  logic              ldx_vld_i,
   input  logic [ADDR_W-1:0] ldx_addr_i,
   input  logic [2:0]        ldx_size_i,
   input  logic              st_vld_i,
   input  logic [ADDR_W-1:0] st_addr_i,
   input  logic              stx_vld_i,
   input  logic [ADDR_W-1:0] stx_addr_i,
   input  logic [2:0]        stx_size_i,
   output logic              stx_done_o,
   output logic              stx_status_o
);
   localparam int N_TAG = 3;

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("ADDR_W must be at least 2");
      end
      if (IGN_BITS < 0 || IGN_BITS >= ADDR_W) begin : g_bad_ign
         $error("IGN_BITS must lie in 0 .. ADDR_W-1");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_vec [N_TAG];
   logic [ADDR_W-1:0] tag_vec  [N_TAG];

   assign addr_vec[0] = ldx_addr_i;
   assign addr_vec[1] = st_addr_i;
   assign addr_vec[2] = stx_addr_i;

   generate
      for (genvar i = 0; i < N_TAG; i++) begin : g_tag
         lxm_tag #(.ADDR_W(ADDR_W), .IGN_BITS(IGN_BITS)) u_tag (
            .addr_i (addr_vec[i]),
            .tag_o  (tag_vec[i])
         );
      end
   endgenerate

   mop_e              op;
   mstate_e           state_q;
   logic [ADDR_W-1:0] tag_q;
   xsize_e            size_q;

   lxm_arbiter u_arb (
      .ld_vld_i  (ld_vld_i),
      .ldx_vld_i (ldx_vld_i),
      .st_vld_i  (st_vld_i),
      .stx_vld_i (stx_vld_i),
      .op_o      (op)
   );

   lxm_state #(.ADDR_W(ADDR_W)) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_i       (op),
      .ldx_tag_i  (tag_vec[0]),
      .ldx_size_i (xsize_e'(ldx_size_i)),
      .st_tag_i   (tag_vec[1]),
      .state_o    (state_q),
      .tag_o      (tag_q),
      .size_o     (size_q)
   );

   lxm_judge #(.ADDR_W(ADDR_W)) u_judge (
      .clk        (clk),
      .rst_n      (rst_n),
      .stx_vld_i  (stx_vld_i),
      .stx_tag_i  (tag_vec[2]),
      .stx_size_i (xsize_e'(stx_size_i)),
      .state_i    (state_q),
      .tag_i      (tag_q),
      .size_i     (size_q),
      .done_o     (stx_done_o),
      .status_o   (stx_status_o)
   );
endmodule

// File: rtl/lxm_checker.sv
module lxm_checker
   import lxm_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int IGN_BITS = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_vld_i,
   input logic              ldx_vld_i,
   input logic [2:0]        ldx_size_i,
   input logic              st_vld_i,
   input logic              stx_vld_i,
   input logic [ADDR_W-1:0] stx_addr_i,
   input logic [2:0]        stx_size_i,
   input logic              stx_done_o,
   input logic              stx_status_o,
   input mstate_e           state_q,
   input logic [ADDR_W-1:0] tag_q,
   input xsize_e            size_q
);
   logic hi_differs;
   assign hi_differs = ((stx_addr_i ^ tag_q) >> IGN_BITS) != '0;

   a_r10_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
      stx_vld_i |=> stx_done_o);

   a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !stx_vld_i |=> !stx_done_o);

   a_r3_open_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (stx_vld_i && state_q == MON_OPEN) |=> stx_status_o);

   a_r4_tag_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (stx_vld_i && hi_differs) |=> stx_status_o);

   a_r5_size_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (stx_vld_i && stx_size_i != size_q) |=> stx_status_o);

   a_r6_reopen: assert property (@(posedge clk) disable iff (!rst_n)
      stx_vld_i |=> (state_q == MON_OPEN && size_q == SZ_NONE));

   a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
      (ldx_vld_i && !stx_vld_i) |=> (state_q == MON_EXCL && size_q == $past(ldx_size_i)));

   a_r8_load_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_vld_i && !ldx_vld_i && !st_vld_i && !stx_vld_i)
         |=> ($stable(state_q) && $stable(tag_q) && $stable(size_q)));
endmodule

bind excl_local_monitor lxm_checker #(.ADDR_W(ADDR_W), .IGN_BITS(IGN_BITS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ld_vld_i     (ld_vld_i),
   .ldx_vld_i    (ldx_vld_i),
   .ldx_size_i   (ldx_size_i),
   .st_vld_i     (st_vld_i),
   .stx_vld_i    (stx_vld_i),
   .stx_addr_i   (stx_addr_i),
   .stx_size_i   (stx_size_i),
   .stx_done_o   (stx_done_o),
   .stx_status_o (stx_status_o),
   .state_q      (state_q),
   .tag_q        (tag_q),
   .size_q       (size_q)
);

// File: tb/excl_local_monitor_tb_top.sv
module excl_local_monitor_tb_top;
   localparam int AW = 32;
   localparam logic [2:0] NONE = 3'd0, BYTE = 3'd1, HALF = 3'd2, WORD = 3'd4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_vld = 1'b0, ldx_vld = 1'b0, st_vld = 1'b0, stx_vld = 1'b0;
   logic [AW-1:0] ldx_addr = '0, st_addr = '0, stx_addr = '0;
   logic [2:0]    ldx_size = NONE, stx_size = NONE;
   logic          stx_done, stx_status;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   bit    exp_q [$];
   string req_q [$];

   always #2 clk = ~clk;

   excl_local_monitor #(.ADDR_W(AW), .IGN_BITS(11)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .ld_vld_i     (ld_vld),
      .ldx_vld_i    (ldx_vld),
      .ldx_addr_i   (ldx_addr),
      .ldx_size_i   (ldx_size),
      .st_vld_i     (st_vld),
      .st_addr_i    (st_addr),
      .stx_vld_i    (stx_vld),
      .stx_addr_i   (stx_addr),
      .stx_size_i   (stx_size),
      .stx_done_o   (stx_done),
      .stx_status_o (stx_status)
   );

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // One cycle of stimulus, applied at the falling edge.
   task automatic step(input bit ld, input bit ldx, input bit st, input bit stx,
                       input logic [AW-1:0] a_ldx, input logic [2:0] s_ldx,
                       input logic [AW-1:0] a_st,
                       input logic [AW-1:0] a_stx, input logic [2:0] s_stx,
                       input bit exp_fail, input string req);
      @(negedge clk);
      ld_vld = ld; ldx_vld = ldx; st_vld = st; stx_vld = stx;
      ldx_addr = a_ldx; ldx_size = s_ldx; st_addr = a_st;
      stx_addr = a_stx; stx_size = s_stx;
      if (stx) begin
         exp_q.push_back(exp_fail);
         req_q.push_back(req);
      end
   endtask

   task automatic do_ldx(input logic [AW-1:0] a, input logic [2:0] s);
      step(0, 1, 0, 0, a, s, '0, '0, NONE, 0, "");
   endtask

   task automatic do_stx(input logic [AW-1:0] a, input logic [2:0] s,
                         input bit exp_fail, input string req);
      step(0, 0, 0, 1, '0, NONE, '0, a, s, exp_fail, req);
   endtask

   task automatic do_st(input logic [AW-1:0] a);
      step(0, 0, 1, 0, '0, NONE, a, '0, NONE, 0, "");
   endtask

   task automatic idle();
      step(0, 0, 0, 0, '0, NONE, '0, '0, NONE, 0, "");
   endtask

   // Monitor: every result pops one expected item.
   always @(negedge clk) begin
      if (rst_n && stx_done && !finished) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R10: done with no pending store, actual done=1 expected done=0");
         end else begin
            bit    e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            if (stx_status !== e) begin
               n_bad++;
               $display("FAIL %s: status actual=%0b expected=%0b", r, stx_status, e);
            end
         end
      end
   end

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      n_cmp++;
      if (stx_done !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: done in reset actual=%0b expected=0", stx_done);
      end
      rst_n = 1'b1;

      // R1: no exclusive load yet
      do_stx(32'h1000, WORD, 1, "R1");
      do_stx(32'h1000, NONE, 1, "R1");

      // R3 pass, then R6 repeat fails (consecutive stores also check R10)
      do_ldx(32'h1000, WORD);
      do_stx(32'h1000, WORD, 0, "R3");
      do_stx(32'h1000, WORD, 1, "R6");

      // R4 granule boundaries
      do_ldx(32'h1000, WORD);
      do_stx(32'h17FC, WORD, 0, "R4");
      do_ldx(32'h1000, WORD);
      do_stx(32'h1800, WORD, 1, "R4");
      do_ldx(32'h1000, WORD);
      do_stx(32'h8000_1000, WORD, 1, "R4");

      // R5 size
      do_ldx(32'h2000, HALF);
      do_stx(32'h2000, BYTE, 1, "R5");
      do_ldx(32'h2000, BYTE);
      do_stx(32'h2001, BYTE, 0, "R5");

      // R2 re-arm replaces record
      do_ldx(32'h3000, WORD);
      do_ldx(32'h5000, WORD);
      do_stx(32'h3000, WORD, 1, "R2");
      do_ldx(32'h3000, WORD);
      do_ldx(32'h5000, HALF);
      do_stx(32'h5000, HALF, 0, "R2");

      // R7 ordinary store
      do_ldx(32'h6000, WORD);
      do_st(32'h6010);
      do_stx(32'h6000, WORD, 1, "R7");
      do_ldx(32'h6000, WORD);
      do_st(32'h9000);
      do_stx(32'h6000, WORD, 0, "R7");

      // R8 ordinary load
      do_ldx(32'h7000, WORD);
      step(1, 0, 0, 0, '0, NONE, '0, '0, NONE, 0, "");
      do_stx(32'h7000, WORD, 0, "R8");

      // R9 collisions
      do_ldx(32'h8000, WORD);
      step(0, 1, 0, 1, 32'h8000, WORD, '0, 32'h8000, WORD, 0, "R9");
      do_stx(32'h8000, WORD, 1, "R9");
      step(0, 1, 0, 1, 32'h8000, WORD, '0, 32'h8000, WORD, 1, "R9");
      do_stx(32'h8000, WORD, 1, "R9");
      step(0, 1, 1, 0, 32'h8000, WORD, 32'h8000, '0, NONE, 0, "");
      do_stx(32'h8000, WORD, 0, "R9");
      do_ldx(32'h8000, WORD);
      step(0, 0, 1, 1, '0, NONE, 32'h8000, 32'h8000, WORD, 0, "R9");

      idle();
      idle();
      idle();
      n_cmp++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R10: results missing actual=%0d pending expected=0", exp_q.size());
      end
      finish_run();
   end
endmodule